// File: doc/BRIEF.md
# Paged Multi-Channel DMA Engine

This block moves data between peripherals and memory on behalf of several independent channels. Software programs each channel through a small register window: a free mode word, a control and status word, a remaining byte count and a logical start address. A peripheral then asks for a burst on one channel, giving the direction and the number of bytes it wants. The engine first checks that the channel is switched on and that the channel's programmed direction agrees with the request. It limits the burst to the bytes still owed, and then moves the data one 32-bit word at a time over a valid/ready memory port.

Every word's logical address passes through a page map held in an internal RAM. Software fills this RAM through the same register bus. A logical address is cut into 4 KiB pages, and the page number selects a map slot. The slot's frame value plus the offset within the page gives the physical address. A slot whose frame is zero is treated as a hole. A request that fails the channel check moves nothing. Instead it raises a memory-error flag in the channel's status word and sets that channel's bit in a sticky NMI source register. A word that lands in a hole, or beyond the last slot, stops the burst and sets an address-error flag.

Top module: `xdma_top`

## Requirements
- R1: After reset every channel register reads 0, the NMI source register (byte offset 0x200) reads 0, `req_ready` is 1, `mem_valid` is 0, and every page-map slot is a hole.
- R2: Channel c register k (k=0 mode, 1 control/status, 2 byte count, 3 logical address) sits at byte offset 0x100 + 0x20*c + 8*k. A read with `reg_re` returns the value on `reg_rdata` after the next clock edge, and the mode word reads back as written.
- R3: When a request is accepted, status bits 8, 9 and 10 of that channel are cleared before any new flag is set.
- R4: If status bit 0 (enable) is 0, or if `req_write` equals status bit 1 (1 = memory-to-device, 0 = device-to-memory), no memory access is made. Status bit 9 and NMI source bit c are set, and `req_done` pulses with `req_err` = 1. NMI bits are never cleared except by reset.
- R5: The burst moves min(`req_len`, count)/4 words. After each word the count drops by 4 and the logical address rises by 4. When the last word completes, status bit 8 is set and `req_done` pulses with `req_err` = 0.
- R6: The physical address of a word is frame + (logical address & 0xFFF). The frame comes from map slot (logical address >> 12).
- R7: A word whose slot is a hole, or whose slot index is 512 or more, is not issued. The burst stops, status bit 10 is set, `req_err` = 1, and the count and address reflect only the words already moved.
- R8: Map slot i is written at byte offset 0x2000 + 8*i. A write to offset 0x2000 + 8*i + 4 (owner word) has no effect. Rewriting a frame word maps the slot (nonzero) or unmaps it (zero) for all later words.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_we` hold. Each handshake moves exactly one word.
- R10: For memory-to-device words, `mem_we` is 0 and the returned `mem_rdata` appears on `dev_dout` with a one-cycle `dev_dout_valid`. For device-to-memory words, `mem_we` is 1, `mem_wdata` carries `dev_din`, and `dev_take` marks the handshake cycle.
- R11: A request whose clamped length is below 4 bytes makes no memory access. It sets status bit 8 and completes with `req_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register bus write strobe |
| reg_re | input | 1 | Register bus read strobe |
| reg_addr | input | 14 | Register bus byte address (bit 13 selects the page map) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Burst request strobe |
| req_ch | input | 3 | Requesting channel |
| req_write | input | 1 | 1 = device-to-memory, 0 = memory-to-device |
| req_len | input | 16 | Requested bytes |
| req_ready | output | 1 | Engine idle, request accepted |
| req_done | output | 1 | Burst finished (pulse) |
| req_err | output | 1 | Burst refused or aborted (with req_done) |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| dev_din | input | 32 | Word supplied by the peripheral |
| dev_take | output | 1 | dev_din consumed this cycle |
| dev_dout | output | 32 | Word delivered to the peripheral |
| dev_dout_valid | output | 1 | dev_dout valid (pulse) |

## Verification
The hardest situation to reach is a burst that runs out of mapped memory part-way. It has to cross a page boundary into a hole after some words have already moved, so the remaining count and address must show partial progress. The stimulus sets a channel's start address a single word below the end of a mapped page, with the following slot left empty. It then remaps that slot and issues the request again, checking that only a frame-word write changes the outcome. All bursts run against a memory that stalls one cycle in three, so that the hold rule and the one-word-per-handshake rule are tested under back-pressure.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  localparam int unsigned K_MODE = 0;
  localparam int unsigned K_STAT = 1;
  localparam int unsigned K_CNT  = 2;
  localparam int unsigned K_ADDR = 3;

  localparam logic [31:0] F_TC   = 32'h0000_0100;
  localparam logic [31:0] F_MERR = 32'h0000_0200;
  localparam logic [31:0] F_AERR = 32'h0000_0400;
  localparam logic [31:0] F_ALL  = F_TC | F_MERR | F_AERR;

  localparam int unsigned PAGE_BITS = 12;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_XLAT, S_MEM} eng_st_t;
endpackage

// File: rtl/xdma_regs.sv
module xdma_regs #(
  parameter int unsigned CH   = 8,
  parameter int unsigned AW   = 14,
  localparam int unsigned CW  = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic          sw_re,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic [CW-1:0] sel_ch,
  output logic [31:0]   sel_stat,
  output logic [31:0]   sel_cnt,
  output logic [31:0]   sel_addr,
  input  logic          eng_stat_we,
  input  logic [31:0]   eng_stat,
  input  logic          eng_ca_we,
  input  logic [31:0]   eng_cnt,
  input  logic [31:0]   eng_addr,
  input  logic          nmi_we,
  output logic [CH-1:0] nmi
);
  localparam logic [AW-1:0] BASE  = AW'(32'h100);
  localparam logic [AW-1:0] LIMIT = AW'(32'h100 + CH * 32);
  localparam logic [AW-1:0] NMI_A = AW'(32'h200);

  logic [31:0] a_mode [CH];
  logic [31:0] a_stat [CH];
  logic [31:0] a_cnt  [CH];
  logic [31:0] a_addr [CH];

  logic [AW-1:0] off;
  logic          hit;
  logic [CW-1:0] w_ch;
  logic [1:0]    w_k;

  assign off  = sw_addr - BASE;
  assign hit  = (sw_addr >= BASE) && (sw_addr < LIMIT) && (sw_addr[2:0] == 3'd0);
  assign w_ch = off[CW+4:5];
  assign w_k  = off[4:3];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [31:0] r_mode, r_stat, r_cnt, r_addr;
    logic        mine, eng;
    assign mine = sw_we && hit && (w_ch == CW'(c));
    assign eng  = (sel_ch == CW'(c));
    always_ff @(posedge clk) begin
      if (rst) begin
        r_mode <= '0;
        r_stat <= '0;
        r_cnt  <= '0;
        r_addr <= '0;
      end else begin
        if (mine && w_k == 2'(xdma_pkg::K_MODE)) r_mode <= sw_wdata;
        if (eng && eng_stat_we) r_stat <= eng_stat;
        else if (mine && w_k == 2'(xdma_pkg::K_STAT)) r_stat <= sw_wdata;
        if (eng && eng_ca_we) begin
          r_cnt  <= eng_cnt;
          r_addr <= eng_addr;
        end else begin
          if (mine && w_k == 2'(xdma_pkg::K_CNT))  r_cnt  <= sw_wdata;
          if (mine && w_k == 2'(xdma_pkg::K_ADDR)) r_addr <= sw_wdata;
        end
      end
    end
    assign a_mode[c] = r_mode;
    assign a_stat[c] = r_stat;
    assign a_cnt[c]  = r_cnt;
    assign a_addr[c] = r_addr;
  end

  assign sel_stat = a_stat[sel_ch];
  assign sel_cnt  = a_cnt[sel_ch];
  assign sel_addr = a_addr[sel_ch];

  always_ff @(posedge clk) begin
    if (rst) nmi <= '0;
    else if (nmi_we) nmi[sel_ch] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sw_rdata <= '0;
    else if (sw_re) begin
      if (hit) begin
        case (w_k)
          2'd0:    sw_rdata <= a_mode[w_ch];
          2'd1:    sw_rdata <= a_stat[w_ch];
          2'd2:    sw_rdata <= a_cnt[w_ch];
          default: sw_rdata <= a_addr[w_ch];
        endcase
      end else if (sw_addr == NMI_A) begin
        sw_rdata <= 32'(nmi);
      end else begin
        sw_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/xdma_xlat.sv
module xdma_xlat #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_frame,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_frame,
  output logic          rd_mapped
);
  logic [31:0]        ram [ENTRIES];
  logic [ENTRIES-1:0] mapped;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= wr_frame;
    rd_frame <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped    <= '0;
      rd_mapped <= 1'b0;
    end else begin
      if (wr_en) mapped[wr_idx] <= |wr_frame;
      rd_mapped <= mapped[rd_idx];
    end
  end
endmodule

// File: rtl/xdma_engine.sv
module xdma_engine #(
  parameter int unsigned CH      = 8,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned CW     = $clog2(CH),
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CW-1:0]    req_ch,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             req_done,
  output logic             req_err,
  output logic [CW-1:0]    sel_ch,
  input  logic [31:0]      stat_in,
  input  logic [31:0]      cnt_in,
  input  logic [31:0]      addr_in,
  output logic             stat_we,
  output logic [31:0]      stat_out,
  output logic             ca_we,
  output logic [31:0]      cnt_out,
  output logic [31:0]      addr_out,
  output logic             nmi_we,
  output logic [IW-1:0]    tbl_idx,
  input  logic [31:0]      tbl_frame,
  input  logic             tbl_mapped,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      dev_din,
  output logic             dev_take,
  output logic [31:0]      dev_dout,
  output logic             dev_dout_valid
);
  import xdma_pkg::*;

  eng_st_t          st;
  logic [CW-1:0]    ch_r;
  logic             dir_r;
  logic [LEN_W-1:0] left;
  logic             oor;
  logic             bad;
  logic [31:0]      eff;
  logic [LEN_W-1:0] words;
  logic [31:0]      clr;

  assign req_ready = (st == S_IDLE);
  assign sel_ch    = (st == S_IDLE) ? req_ch : ch_r;
  assign tbl_idx   = addr_in[PAGE_BITS +: IW];
  assign mem_wdata = dev_din;
  assign dev_take  = mem_valid && mem_ready && mem_we;

  assign bad   = !stat_in[0] || (req_write == stat_in[1]);
  assign eff   = (32'(req_len) < cnt_in) ? 32'(req_len) : cnt_in;
  assign words = LEN_W'(eff >> 2);
  assign clr   = stat_in & ~F_ALL;

  always_comb begin
    stat_we  = 1'b0;
    stat_out = stat_in;
    ca_we    = 1'b0;
    cnt_out  = cnt_in - 32'd4;
    addr_out = addr_in + 32'd4;
    nmi_we   = 1'b0;
    case (st)
      S_IDLE: if (req_valid) begin
        stat_we = 1'b1;
        if (bad) begin
          stat_out = clr | F_MERR;
          nmi_we   = 1'b1;
        end else if (words == '0) begin
          stat_out = clr | F_TC;
        end else begin
          stat_out = clr;
        end
      end
      S_XLAT: if (!tbl_mapped || oor) begin
        stat_we  = 1'b1;
        stat_out = stat_in | F_AERR;
      end
      S_MEM: if (mem_ready) begin
        ca_we = 1'b1;
        if (left == LEN_W'(1)) begin
          stat_we  = 1'b1;
          stat_out = stat_in | F_TC;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_IDLE;
      ch_r           <= '0;
      dir_r          <= 1'b0;
      left           <= '0;
      oor            <= 1'b0;
      mem_valid      <= 1'b0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      req_done       <= 1'b0;
      req_err        <= 1'b0;
      dev_dout       <= '0;
      dev_dout_valid <= 1'b0;
    end else begin
      req_done       <= 1'b0;
      req_err        <= 1'b0;
      dev_dout_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ch_r  <= req_ch;
          dir_r <= req_write;
          left  <= words;
          if (bad) begin
            req_done <= 1'b1;
            req_err  <= 1'b1;
          end else if (words == '0) begin
            req_done <= 1'b1;
          end else begin
            st <= S_LOOK;
          end
        end
        S_LOOK: begin
          oor <= (addr_in[31:PAGE_BITS] >= (32-PAGE_BITS)'(ENTRIES));
          st  <= S_XLAT;
        end
        S_XLAT: begin
          if (!tbl_mapped || oor) begin
            req_done <= 1'b1;
            req_err  <= 1'b1;
            st       <= S_IDLE;
          end else begin
            mem_valid <= 1'b1;
            mem_we    <= dir_r;
            mem_addr  <= tbl_frame + {{(32-PAGE_BITS){1'b0}}, addr_in[PAGE_BITS-1:0]};
            st        <= S_MEM;
          end
        end
        S_MEM: if (mem_ready) begin
          mem_valid <= 1'b0;
          if (!dir_r) begin
            dev_dout       <= mem_rdata;
            dev_dout_valid <= 1'b1;
          end
          left <= left - LEN_W'(1);
          if (left == LEN_W'(1)) begin
            req_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_LOOK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xdma_top.sv
module xdma_top #(
  parameter int unsigned CH      = 8,
  parameter int unsigned AW      = 14,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned CW     = $clog2(CH),
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  input  logic [CW-1:0]    req_ch,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  output logic             req_done,
  output logic             req_err,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      dev_din,
  output logic             dev_take,
  output logic [31:0]      dev_dout,
  output logic             dev_dout_valid
);
  logic          map_sel;
  logic [AW-2:0] map_off;
  logic          tbl_we;
  logic [CW-1:0] sel_ch;
  logic [31:0]   sel_stat, sel_cnt, sel_addr;
  logic          stat_we, ca_we, nmi_we;
  logic [31:0]   stat_out, cnt_out, addr_out;
  logic [CH-1:0] nmi_src;
  logic [IW-1:0] tbl_idx;
  logic [31:0]   tbl_frame;
  logic          tbl_mapped;

  assign map_sel = reg_addr[AW-1];
  assign map_off = reg_addr[AW-2:0];
  assign tbl_we  = reg_we && map_sel && (map_off[2:0] == 3'd0) &&
                   (32'(map_off >> 3) < ENTRIES);

  xdma_regs #(.CH(CH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst),
    .sw_we(reg_we && !map_sel), .sw_re(reg_re), .sw_addr(reg_addr),
    .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .sel_ch(sel_ch), .sel_stat(sel_stat), .sel_cnt(sel_cnt), .sel_addr(sel_addr),
    .eng_stat_we(stat_we), .eng_stat(stat_out),
    .eng_ca_we(ca_we), .eng_cnt(cnt_out), .eng_addr(addr_out),
    .nmi_we(nmi_we), .nmi(nmi_src)
  );

  xdma_xlat #(.ENTRIES(ENTRIES)) u_xlat (
    .clk(clk), .rst(rst),
    .wr_en(tbl_we), .wr_idx(map_off[IW+2:3]), .wr_frame(reg_wdata),
    .rd_idx(tbl_idx), .rd_frame(tbl_frame), .rd_mapped(tbl_mapped)
  );

  xdma_engine #(.CH(CH), .LEN_W(LEN_W), .ENTRIES(ENTRIES)) u_eng (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ch(req_ch), .req_write(req_write), .req_len(req_len),
    .req_ready(req_ready), .req_done(req_done), .req_err(req_err),
    .sel_ch(sel_ch), .stat_in(sel_stat), .cnt_in(sel_cnt), .addr_in(sel_addr),
    .stat_we(stat_we), .stat_out(stat_out), .ca_we(ca_we),
    .cnt_out(cnt_out), .addr_out(addr_out), .nmi_we(nmi_we),
    .tbl_idx(tbl_idx), .tbl_frame(tbl_frame), .tbl_mapped(tbl_mapped),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_din(dev_din), .dev_take(dev_take),
    .dev_dout(dev_dout), .dev_dout_valid(dev_dout_valid)
  );
endmodule

// File: rtl/xdma_chk.sv
module xdma_chk #(
  parameter int unsigned CH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [31:0]   mem_addr,
  input logic          req_ready,
  input logic          req_done,
  input logic [CH-1:0] nmi
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (req_ready && !mem_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (req_ready && !mem_valid));

  p_nmi_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((nmi & $past(nmi)) == $past(nmi)));

  p_nmi_single_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(nmi ^ $past(nmi)) <= 1));
endmodule

bind xdma_top xdma_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .req_ready(req_ready),
  .req_done(req_done), .nmi(nmi_src)
);

// File: tb/tb_xdma_top.sv
module tb_xdma_top;
  localparam logic [31:0] KEY = 32'h5A5A_0000;
  localparam logic [31:0] DIN = 32'hD000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_ch = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_len = '0;
  logic        req_ready, req_done, req_err;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] dev_din;
  logic        dev_take;
  logic [31:0] dev_dout;
  logic        dev_dout_valid;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_log = 0;
  int n_out = 0;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic [31:0] log_wd   [64];
  logic [31:0] out_log  [64];

  always #4 clk = ~clk;

  xdma_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ch(req_ch), .req_write(req_write), .req_len(req_len),
    .req_ready(req_ready), .req_done(req_done), .req_err(req_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_din(dev_din), .dev_take(dev_take), .dev_dout(dev_dout),
    .dev_dout_valid(dev_dout_valid)
  );

  assign mem_rdata = mem_addr ^ KEY;
  assign dev_din   = DIN | 32'(n_log);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= ((cyc % 3) != 1);
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && n_log < 64) begin
      log_addr[n_log] <= mem_addr;
      log_we[n_log]   <= mem_we;
      log_wd[n_log]   <= mem_wdata;
      n_log <= n_log + 1;
    end
    if (dev_dout_valid && n_out < 64) begin
      out_log[n_out] <= dev_dout;
      n_out <= n_out + 1;
    end
  end

  function automatic logic [13:0] creg(input int c, input int k);
    return 14'(32'h100 + c * 32 + k * 8);
  endfunction

  function automatic logic [13:0] slot(input int i, input int w);
    return 14'(32'h2000 + i * 8 + w * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic prog(input int c, input logic [31:0] st, input logic [31:0] cnt,
                      input logic [31:0] la);
    wr(creg(c, 1), st);
    wr(creg(c, 2), cnt);
    wr(creg(c, 3), la);
  endtask

  task automatic run(input int c, input bit w, input int len, output bit err);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_ch = 3'(c); req_write = w; req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    err = req_err;
    @(negedge clk);
  endtask

  task automatic expect_ch(input string tag, input int c, input logic [31:0] st,
                           input logic [31:0] cnt, input logic [31:0] la);
    logic [31:0] v;
    rd(creg(c, 1), v); check({tag, " status"}, v, st);
    rd(creg(c, 2), v); check({tag, " count"}, v, cnt);
    rd(creg(c, 3), v); check({tag, " address"}, v, la);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bit e;
    int s;
    rd(creg(0, 1), v); check("R1 ch0 status", v, 0);
    rd(creg(7, 3), v); check("R1 ch7 address", v, 0);
    rd(14'h200, v);    check("R1 nmi source", v, 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 mem_valid", 32'(mem_valid), 0);
    s = n_log;
    prog(0, 32'h3, 8, 32'h1000);
    run(0, 1'b0, 8, e);
    check("R1 empty map aborts", 32'(e), 1);
    check("R1 empty map no access", 32'(n_log - s), 0);
    expect_ch("R1 empty map", 0, 32'h403, 8, 32'h1000);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(creg(3, 0), 32'hCAFE_0003);
    wr(creg(5, 2), 32'h0000_1234);
    rd(creg(3, 0), v); check("R2 mode ch3", v, 32'hCAFE_0003);
    rd(creg(5, 2), v); check("R2 count ch5", v, 32'h1234);
    rd(creg(4, 2), v); check("R2 neighbour untouched", v, 0);
  endtask

  task automatic t_read_burst;
    bit e;
    int s, so;
    wr(slot(1, 0), 32'h0004_0000);
    wr(slot(2, 0), 32'h0000_9000);
    prog(1, 32'h603, 64, 32'h1FF8);
    s = n_log; so = n_out;
    run(1, 1'b0, 16, e);
    check("R5 read ok", 32'(e), 0);
    check("R9 one word per handshake", 32'(n_log - s), 4);
    check("R6 page1 word0", log_addr[s],     32'h0004_0FF8);
    check("R6 page1 word1", log_addr[s + 1], 32'h0004_0FFC);
    check("R6 page2 word2", log_addr[s + 2], 32'h0000_9000);
    check("R6 page2 word3", log_addr[s + 3], 32'h0000_9004);
    check("R10 read is not write", 32'(log_we[s]), 0);
    for (int i = 0; i < 4; i++)
      check("R10 dev_dout data", out_log[so + i], log_addr[s + i] ^ KEY);
    expect_ch("R3 R5 read burst", 1, 32'h103, 48, 32'h2008);
  endtask

  task automatic t_write_clamp;
    bit e;
    int s;
    prog(2, 32'h1, 8, 32'h1000);
    s = n_log;
    run(2, 1'b1, 20, e);
    check("R5 clamp ok", 32'(e), 0);
    check("R5 clamped words", 32'(n_log - s), 2);
    check("R10 write addr0", log_addr[s], 32'h0004_0000);
    check("R10 write addr1", log_addr[s + 1], 32'h0004_0004);
    check("R10 write flag", 32'(log_we[s]), 1);
    check("R10 write data0", log_wd[s], DIN | 32'(s));
    check("R10 write data1", log_wd[s + 1], DIN | 32'(s + 1));
    expect_ch("R5 write clamp", 2, 32'h101, 0, 32'h1008);
  endtask

  task automatic t_mismatch;
    logic [31:0] v;
    bit e;
    int s;
    s = n_log;
    prog(4, 32'h501, 16, 32'h1000);
    run(4, 1'b0, 8, e);
    check("R4 direction err", 32'(e), 1);
    expect_ch("R3 R4 direction", 4, 32'h201, 16, 32'h1000);
    rd(14'h200, v); check("R4 nmi bit4", v, 32'h10);
    prog(6, 32'h0, 16, 32'h1000);
    run(6, 1'b1, 8, e);
    check("R4 disabled err", 32'(e), 1);
    rd(creg(6, 1), v); check("R4 disabled status", v, 32'h200);
    prog(3, 32'h3, 16, 32'h1000);
    run(3, 1'b1, 8, e);
    rd(creg(3, 1), v); check("R4 reversed status", v, 32'h203);
    rd(14'h200, v); check("R4 nmi accumulate", v, 32'h58);
    check("R4 no memory access", 32'(n_log - s), 0);
  endtask

  task automatic t_unmapped;
    bit e;
    int s;
    prog(0, 32'h3, 32, 32'h2FFC);
    s = n_log;
    run(0, 1'b0, 8, e);
    check("R7 hole err", 32'(e), 1);
    check("R7 one word before hole", 32'(n_log - s), 1);
    check("R7 word before hole addr", log_addr[s], 32'h0000_9FFC);
    expect_ch("R7 hole", 0, 32'h403, 28, 32'h3000);
    prog(7, 32'h3, 8, 32'h0020_0000);
    s = n_log;
    run(7, 1'b0, 8, e);
    check("R7 slot 512 err", 32'(e), 1);
    check("R7 slot 512 no access", 32'(n_log - s), 0);
    expect_ch("R7 slot 512", 7, 32'h403, 8, 32'h0020_0000);
  endtask

  task automatic t_remap;
    bit e;
    int s;
    wr(slot(3, 1), 32'h0000_7777);
    s = n_log;
    run(0, 1'b0, 4, e);
    check("R8 owner word ignored", 32'(e), 1);
    check("R8 owner word no access", 32'(n_log - s), 0);
    wr(slot(3, 0), 32'h0000_7000);
    s = n_log;
    run(0, 1'b0, 4, e);
    check("R8 remap ok", 32'(e), 0);
    check("R8 remap addr", log_addr[s], 32'h0000_7000);
    expect_ch("R8 remap", 0, 32'h103, 24, 32'h3004);
    wr(slot(2, 0), 32'h0);
    wr(creg(0, 3), 32'h2000);
    s = n_log;
    run(0, 1'b0, 4, e);
    check("R8 unmap err", 32'(e), 1);
    check("R8 unmap no access", 32'(n_log - s), 0);
  endtask

  task automatic t_zero;
    bit e;
    int s;
    prog(5, 32'h1, 0, 32'h1000);
    s = n_log;
    run(5, 1'b1, 8, e);
    check("R11 zero ok", 32'(e), 0);
    check("R11 zero no access", 32'(n_log - s), 0);
    expect_ch("R11 zero", 5, 32'h101, 0, 32'h1000);
    prog(5, 32'h1, 16, 32'h1000);
    run(5, 1'b1, 3, e);
    check("R11 short len ok", 32'(e), 0);
    check("R11 short len no access", 32'(n_log - s), 0);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_read_burst();
    t_write_clamp();
    t_mismatch();
    t_unmapped();
    t_remap();
    t_zero();
    finish_up();
  end
endmodule